// File: doc/BRIEF.md
# Modem Status and Control Register

This block sits beside the serial engine of a UART-style communications element. It watches four asynchronous active-low modem lines: clear-to-send, data-set-ready, carrier detect and ring indicator. Each line passes through a two-flop synchroniser. The block reports the present level of each line and a sticky change flag for each line, all in one 8-bit status byte. Reading the byte clears the change flags.

The block raises a modem-status interrupt request when the enable bit is set and an eligible change flag is pending. While automatic CTS flow control is on, clear-to-send changes are still recorded but do not interrupt. The block also drives the active-low data-terminal-ready output from a control bit. That output is forced inactive during loop mode and during reset.

Top module: `modem_status_ctrl`

## Requirements
- R1: Status bit 4 is 1 while `cts_n` is low; bit 0 is set when the synchronised `cts_n` changes in either direction.
- R2: Status bit 5 is 1 while `dsr_n` is low; bit 1 is set when the synchronised `dsr_n` changes in either direction.
- R3: Status bit 7 is 1 while `dcd_n` is low; bit 3 is set when the synchronised `dcd_n` changes in either direction.
- R4: Status bit 6 is 1 while `ri_n` is low. Bit 2 is set only when the synchronised `ri_n` goes from low to high (ring ends). A high-to-low change of `ri_n` leaves bit 2 unchanged.
- R5: A pin level sampled at one rising edge shows in bits 7:4 after the second rising edge. A change sets its flag at the third rising edge.
- R6: A status read (`msr_rd` high at a rising edge) clears flag bits 3:0 at that edge, and `msr_q` shows the value from before the clear during the read cycle. A change detected at the same edge still sets its flag.
- R7: `msi_irq` is high exactly when `msi_en` is high and at least one flag among bits 3:1 is set, or bit 0 is set while `auto_cts` is low.
- R8: With `auto_cts` high, bit 0 still sets on a CTS change, but bit 0 alone does not raise `msi_irq`.
- R9: `dtr_n` is low exactly when `dtr_ctl` is high, `loop_mode` is low and reset is not asserted.
- R10: While `rst_n` is low, `msr_q` reads 0x00, `msi_irq` is low and `dtr_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send line, asynchronous, active low |
| dsr_n | input | 1 | Data-set-ready line, asynchronous, active low |
| dcd_n | input | 1 | Carrier-detect line, asynchronous, active low |
| ri_n | input | 1 | Ring-indicator line, asynchronous, active low |
| msr_rd | input | 1 | Status read strobe; clears the change flags |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts | input | 1 | Automatic CTS flow control active |
| loop_mode | input | 1 | Loop mode active |
| dtr_ctl | input | 1 | Data-terminal-ready control bit |
| msr_q | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| msi_irq | output | 1 | Modem-status interrupt request |
| dtr_n | output | 1 | Data-terminal-ready output, active low |

## Verification
The two functions that can fall in the same cycle are the clear-on-read of the flags and the setting of a flag by a newly detected change. The bench provokes this in a directed test. It toggles `cts_n` and raises `msr_rd` exactly two falling edges later, so the read and the flag update land on the same rising edge. It also provokes it many times through random reads mixed with random pin activity. A behavioural model keeps a history of the sampled pins. Every cycle it judges whether the flag survives the clear and whether the interrupt follows the enable and auto-CTS mask.

// File: rtl/modem_status_ctrl.sv
module modem_status_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       dcd_n,
  input  logic       ri_n,
  input  logic       msr_rd,
  input  logic       msi_en,
  input  logic       auto_cts,
  input  logic       loop_mode,
  input  logic       dtr_ctl,
  output logic [7:0] msr_q,
  output logic       msi_irq,
  output logic       dtr_n
);

  // line order in every vector: {dcd, ri, dsr, cts}
  logic [3:0] pins, meta, sync, held, chg, flags, irq_src;

  assign pins = {dcd_n, ri_n, dsr_n, cts_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= '1;
      sync  <= '1;
      held  <= '1;
      flags <= '0;
    end else begin
      meta  <= pins;
      sync  <= meta;
      held  <= sync;
      flags <= (msr_rd ? 4'b0 : flags) | chg;
    end
  end

  assign chg = {sync[3] ^ held[3], sync[2] & ~held[2], sync[1] ^ held[1], sync[0] ^ held[0]};

  assign msr_q   = {~sync, flags};
  assign irq_src = {flags[3:1], flags[0] & ~auto_cts};
  assign msi_irq = msi_en & (|irq_src);
  assign dtr_n   = ~(rst_n & dtr_ctl & ~loop_mode);

  AST_CTS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msr_q[4]) |=> msr_q[0]); // R1
  AST_DSR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msr_q[5]) |=> msr_q[1]); // R2
  AST_DCD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(msr_q[7]) |=> msr_q[3]); // R3
  AST_RING_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msr_q[6]) |=> msr_q[2]); // R4
  AST_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && chg == 4'b0) |=> msr_q[3:0] == 4'b0); // R6
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !msi_irq); // R7
  AST_CTS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts && msr_q[3:1] == 3'b0) |-> !msi_irq); // R8
  AST_DTR_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_mode |-> dtr_n); // R9

endmodule

// File: tb/modem_status_ctrl_bench.sv
module modem_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cts_n = 1, dsr_n = 1, dcd_n = 1, ri_n = 1;
  logic msr_rd = 0, msi_en = 0, auto_cts = 0, loop_mode = 0, dtr_ctl = 0;
  logic [7:0] msr_q;
  logic msi_irq, dtr_n;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  // model: history of sampled pins, newest first; index 1 is the visible level
  logic [3:0] hist [$] = '{4'hF, 4'hF, 4'hF, 4'hF};
  logic [3:0] m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_status_ctrl u_modem_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
    .msr_rd(msr_rd), .msi_en(msi_en), .auto_cts(auto_cts), .loop_mode(loop_mode),
    .dtr_ctl(dtr_ctl), .msr_q(msr_q), .msi_irq(msi_irq), .dtr_n(dtr_n));

  always @(posedge clk) begin
    logic [3:0] nw, od, ev;
    cycles++;
    if (!rst_n) begin
      hist = '{4'hF, 4'hF, 4'hF, 4'hF};
      m_flag = 0;
    end else begin
      nw = hist[1];
      od = hist[2];
      ev = 0;
      for (int i = 0; i < 4; i++)
        ev[i] = (i == 2) ? (nw[i] & ~od[i]) : (nw[i] ^ od[i]);
      m_flag = (msr_rd ? 4'b0 : m_flag) | ev;
      hist.push_front({dcd_n, ri_n, dsr_n, cts_n});
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (time %0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_msr;
    logic e_irq, e_dtr;
    e_msr = {~hist[1], m_flag};
    e_irq = msi_en & (m_flag[3] | m_flag[2] | m_flag[1] | (m_flag[0] & ~auto_cts));
    e_dtr = ~(rst_n & dtr_ctl & ~loop_mode);
    chg_field(0, 4, "R1/R5/R6");
    chg_field(1, 5, "R2/R5/R6");
    chg_field(3, 7, "R3/R5/R6");
    chg_field(2, 6, "R4/R5/R6");
    chk(msi_irq === e_irq, auto_cts ? "R8" : "R7", {7'b0, msi_irq}, {7'b0, e_irq});
    chk(dtr_n === e_dtr, "R9", {7'b0, dtr_n}, {7'b0, e_dtr});
  endtask

  task automatic chg_field(input int f, input int s, input string tag);
    logic [7:0] e;
    e = {~hist[1], m_flag};
    chk(msr_q[f] === e[f] && msr_q[s] === e[s], tag, msr_q, e);
  endtask

  initial begin : watchdog
    wait (cycles > 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dtr_ctl = 1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(msr_q === 8'h00, "R10", msr_q, 8'h00);
    chk(msi_irq === 1'b0 && dtr_n === 1'b1, "R10", {6'b0, msi_irq, dtr_n}, 8'h01);
    rst_n = 1;
    dtr_ctl = 0;
    @(negedge clk);
    compare_all();

    // R5/R6: directed CTS change with the read landing on the flag-setting edge
    msi_en = 1;
    cts_n = 0;
    @(negedge clk); compare_all();
    @(negedge clk); compare_all();
    chk(msr_q[4] === 1'b1 && msr_q[0] === 1'b0, "R5", msr_q, 8'h10);
    msr_rd = 1;
    @(negedge clk); compare_all();
    msr_rd = 0;
    chk(msr_q[0] === 1'b1 && msi_irq === 1'b1, "R6", msr_q, 8'h11);
    msr_rd = 1;
    @(negedge clk); compare_all();
    msr_rd = 0;
    chk(msr_q[3:0] === 4'h0, "R6", msr_q, 8'h10);

    // R8: CTS change under auto-CTS sets the flag but no interrupt
    auto_cts = 1;
    cts_n = 1;
    repeat (4) begin @(negedge clk); compare_all(); end
    chk(msr_q[0] === 1'b1 && msi_irq === 1'b0, "R8", {msr_q[0], 6'b0, msi_irq}, 8'h80);

    // R4: ring start sets nothing, ring end sets bit 2
    msr_rd = 1; @(negedge clk); compare_all(); msr_rd = 0;
    ri_n = 0;
    repeat (4) begin @(negedge clk); compare_all(); end
    chk(msr_q[2] === 1'b0 && msr_q[6] === 1'b1, "R4", msr_q, 8'h40);
    ri_n = 1;
    repeat (4) begin @(negedge clk); compare_all(); end
    chk(msr_q[2] === 1'b1 && msi_irq === 1'b1, "R4", msr_q, 8'h04);

    // R9: loop mode forces data-terminal-ready inactive
    dtr_ctl = 1; loop_mode = 1;
    @(negedge clk); compare_all();
    chk(dtr_n === 1'b1, "R9", {7'b0, dtr_n}, 8'h01);
    loop_mode = 0;
    @(negedge clk); compare_all();
    chk(dtr_n === 1'b0, "R9", {7'b0, dtr_n}, 8'h00);

    // random mixture of pin activity, reads and control bits
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 5) == 0) dsr_n = ~dsr_n;
      if ($urandom_range(0, 5) == 0) dcd_n = ~dcd_n;
      if ($urandom_range(0, 6) == 0) ri_n = ~ri_n;
      msr_rd = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) msi_en = ~msi_en;
      if ($urandom_range(0, 15) == 0) auto_cts = ~auto_cts;
      if ($urandom_range(0, 15) == 0) loop_mode = ~loop_mode;
      if ($urandom_range(0, 7) == 0) dtr_ctl = ~dtr_ctl;
      @(negedge clk);
      compare_all();
    end

    // R10: reset mid-run
    rst_n = 0;
    #1;
    chk(msr_q === 8'h00 && msi_irq === 1'b0 && dtr_n === 1'b1, "R10", msr_q, 8'h00);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule